// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 16-bit segmented processor core and carries out the memory traffic that enters or leaves an interrupt handler. Requests come from three places: a vectored hardware line (already arbitrated by an external priority controller), a vectored software trap raised by the decoder, and a return request from the handler's exit instruction. Each request is latched. It starts only when the core signals that the instruction in flight has retired.

An entry saves a three-word context on the stack through a single word-wide memory port with a request/ready handshake. It then reads a two-word far pointer from a 256-entry table at the bottom of the address space. Finally it presents the new code segment, instruction pointer, flags and stack pointer to the core on a one-cycle commit strobe. A return pops the same three words in mirrored order and commits them. Stack addresses are formed as segment times 16 plus offset, truncated to the address width.

Top module: `trap_entry_seq`

## Requirements
- R1: No entry or return begins unless `retire` is high in the cycle it starts. A request stays pending (busy low, no memory traffic) until such a retire cycle.
- R2: An entry writes three words. In this order, it writes the sampled flags to SS*16+(SP-2), the code segment to SS*16+(SP-4), and the instruction pointer to SS*16+(SP-6).
- R3: After the pushes, an entry reads the handler offset at byte address vector*4 and then the handler segment at vector*4+2. With an 8-bit vector, both addresses lie in 0x000 to 0x3FF.
- R4: An entry commit presents ip_out = offset word, cs_out = segment word, and sp_out = SP-6. flags_out equals the pushed flags with bit 9 (interrupt enable) and bit 8 (single step) cleared. The pushed flags word itself is unmodified.
- R5: A return reads IP at SS*16+SP, then CS at SS*16+(SP+2), then flags at SS*16+(SP+4). Its commit restores those three words exactly, with sp_out = SP+6.
- R6: A software trap runs the same push, table-read and commit sequence as a hardware request, using `sw_vec` as the vector.
- R7: A pending hardware request is not taken at a retire while flags_in bit 9 is 0. It remains pending and is taken at a later retire once bit 9 is 1. Software traps are taken regardless of bit 9.
- R8: `busy` is high from the cycle after acceptance through the commit cycle, and `commit` is high for exactly one cycle. Requests arriving while busy are held and served at a retire after busy falls.
- R9: While `mem_req` is high and `mem_rdy` low, the sequencer holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R10: When several requests are pending at one retire, the order is return first, then software trap, then hardware request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | Instruction-retired strobe from the core |
| hw_req | input | 1 | Hardware request pulse |
| hw_vec | input | 8 | Hardware vector number |
| sw_req | input | 1 | Software trap pulse |
| sw_vec | input | 8 | Software trap vector number |
| ret_req | input | 1 | Handler return pulse |
| flags_in | input | 16 | Current flags register |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_rdy | input | 1 | Access completes at this edge |
| commit | output | 1 | New register values valid |
| flags_out | output | 16 | Flags to load |
| cs_out | output | 16 | Code segment to load |
| ip_out | output | 16 | Instruction pointer to load |
| sp_out | output | 16 | Stack pointer to load |

## Verification
The bench walks all 256 vectors as software traps, with the interrupt-enable bit varied. Any error in the vector-to-address scaling, or a swapped offset/segment read, shows up as a wrong load address or a wrong new CS:IP on some vector. It holds a hardware request while interrupts are disabled: a design that ignores the mask would enter early, and one that drops the pending request would never enter. It puts return, software and hardware requests in flight together, and injects a request mid-sequence. These catch a wrong priority and a lost or prematurely started request. Varied memory latency exposes any access that moves on, or changes its address, before ready.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_F,
      ST_PUSH_CS,
      ST_PUSH_IP,
      ST_RD_OFF,
      ST_RD_SEG,
      ST_POP_IP,
      ST_POP_CS,
      ST_POP_F,
      ST_COMMIT
   } seq_state_e;

   // request channel indices, lowest index wins arbitration
   localparam int CH_RET = 0;
   localparam int CH_SW  = 1;
   localparam int CH_HW  = 2;
   localparam int NUM_CH = 3;

endpackage

// File: rtl/trap_req_latch.sv
module trap_req_latch #(
   parameter int VEC_W  = 8,
   parameter int NCH    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   req,
   input  logic [VEC_W-1:0] vin  [NCH],
   input  logic [NCH-1:0]   take,
   output logic [NCH-1:0]   pend,
   output logic [VEC_W-1:0] vq   [NCH]
);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic             p_q;
      logic [VEC_W-1:0] v_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            v_q <= '0;
         end else if (req[g] && (!p_q || take[g])) begin
            p_q <= 1'b1;
            v_q <= vin[g];
         end else if (take[g]) begin
            p_q <= 1'b0;
         end
      end

      assign pend[g] = p_q;
      assign vq[g]   = v_q;
   end

endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
   import trap_seq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int VEC_W     = 8,
   parameter int ADDR_W    = 20,
   parameter int SEG_SHIFT = 4
) (
   input  seq_state_e        state,
   input  logic [DATA_W-1:0] ss_q,
   input  logic [DATA_W-1:0] sp_q,
   input  logic [VEC_W-1:0]  vec_q,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam int WORD_BYTES = DATA_W / 8;

   logic [DATA_W-1:0] stk_off;
   logic [ADDR_W-1:0] stk_addr;
   logic [ADDR_W-1:0] tbl_addr;
   logic              is_push;

   assign is_push = (state == ST_PUSH_F) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
   assign stk_off = is_push ? sp_q - DATA_W'(WORD_BYTES) : sp_q;

   if (SEG_SHIFT > 0) begin : g_seg
      assign stk_addr = (ADDR_W'(ss_q) << SEG_SHIFT) + ADDR_W'(stk_off);
   end else begin : g_flat
      assign stk_addr = ADDR_W'(stk_off);
   end

   assign tbl_addr = (ADDR_W'(vec_q) << 2)
                   + ((state == ST_RD_SEG) ? ADDR_W'(WORD_BYTES) : ADDR_W'(0));

   assign mem_addr = ((state == ST_RD_OFF) || (state == ST_RD_SEG)) ? tbl_addr : stk_addr;

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
   import trap_seq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int VEC_W  = 8,
   parameter int IF_BIT = 9,
   parameter int TF_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic [NUM_CH-1:0] pend,
   input  logic [VEC_W-1:0]  vq      [NUM_CH],
   output logic [NUM_CH-1:0] take,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic              mem_rdy,
   input  logic [DATA_W-1:0] mem_rdata,
   output seq_state_e        state,
   output logic [DATA_W-1:0] ss_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [VEC_W-1:0]  vec_q,
   output logic [DATA_W-1:0] flags_q,
   output logic [DATA_W-1:0] cs_q,
   output logic [DATA_W-1:0] ip_q,
   output logic              is_ret,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam logic [DATA_W-1:0] STEP     = DATA_W'(DATA_W / 8);
   localparam logic [DATA_W-1:0] CLR_MASK = (DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT);

   logic eligible;
   logic go;
   logic fire;

   assign eligible = pend[CH_RET] | pend[CH_SW] | (pend[CH_HW] & flags_in[IF_BIT]);
   assign go       = (state == ST_IDLE) && retire && eligible;

   always_comb begin
      take = '0;
      if (go) begin
         if (pend[CH_RET])     take[CH_RET] = 1'b1;
         else if (pend[CH_SW]) take[CH_SW]  = 1'b1;
         else                  take[CH_HW]  = 1'b1;
      end
   end

   always_comb begin
      unique case (state)
         ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: begin mem_req = 1'b1; mem_we = 1'b1; end
         ST_RD_OFF, ST_RD_SEG,
         ST_POP_IP, ST_POP_CS, ST_POP_F:    begin mem_req = 1'b1; mem_we = 1'b0; end
         default:                           begin mem_req = 1'b0; mem_we = 1'b0; end
      endcase
   end

   always_comb begin
      unique case (state)
         ST_PUSH_F:  mem_wdata = flags_q;
         ST_PUSH_CS: mem_wdata = cs_q;
         ST_PUSH_IP: mem_wdata = ip_q;
         default:    mem_wdata = '0;
      endcase
   end

   assign fire = mem_req && mem_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ss_q    <= '0;
         sp_q    <= '0;
         vec_q   <= '0;
         flags_q <= '0;
         cs_q    <= '0;
         ip_q    <= '0;
         is_ret  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (go) begin
               ss_q    <= ss_in;
               sp_q    <= sp_in;
               flags_q <= flags_in;
               cs_q    <= cs_in;
               ip_q    <= ip_in;
               if (pend[CH_RET]) begin
                  is_ret <= 1'b1;
                  state  <= ST_POP_IP;
               end else begin
                  is_ret <= 1'b0;
                  vec_q  <= pend[CH_SW] ? vq[CH_SW] : vq[CH_HW];
                  state  <= ST_PUSH_F;
               end
            end
            ST_PUSH_F: if (fire) begin
               flags_q <= flags_q & ~CLR_MASK;
               sp_q    <= sp_q - STEP;
               state   <= ST_PUSH_CS;
            end
            ST_PUSH_CS: if (fire) begin
               sp_q  <= sp_q - STEP;
               state <= ST_PUSH_IP;
            end
            ST_PUSH_IP: if (fire) begin
               sp_q  <= sp_q - STEP;
               state <= ST_RD_OFF;
            end
            ST_RD_OFF: if (fire) begin
               ip_q  <= mem_rdata;
               state <= ST_RD_SEG;
            end
            ST_RD_SEG: if (fire) begin
               cs_q  <= mem_rdata;
               state <= ST_COMMIT;
            end
            ST_POP_IP: if (fire) begin
               ip_q  <= mem_rdata;
               sp_q  <= sp_q + STEP;
               state <= ST_POP_CS;
            end
            ST_POP_CS: if (fire) begin
               cs_q  <= mem_rdata;
               sp_q  <= sp_q + STEP;
               state <= ST_POP_F;
            end
            ST_POP_F: if (fire) begin
               flags_q <= mem_rdata;
               sp_q    <= sp_q + STEP;
               state   <= ST_COMMIT;
            end
            ST_COMMIT: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_seq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int VEC_W     = 8,
   parameter int ADDR_W    = 20,
   parameter int SEG_SHIFT = 4,
   parameter int IF_BIT    = 9,
   parameter int TF_BIT    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              hw_req,
   input  logic [VEC_W-1:0]  hw_vec,
   input  logic              sw_req,
   input  logic [VEC_W-1:0]  sw_vec,
   input  logic              ret_req,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output logic              commit,
   output logic [DATA_W-1:0] flags_out,
   output logic [DATA_W-1:0] cs_out,
   output logic [DATA_W-1:0] ip_out,
   output logic [DATA_W-1:0] sp_out
);

   if (DATA_W % 8 != 0)          begin : g_bad_w  $error("DATA_W must be whole bytes"); end
   if (VEC_W + 2 > ADDR_W)       begin : g_bad_v  $error("vector table exceeds address space"); end
   if (IF_BIT >= DATA_W)         begin : g_bad_if $error("IF_BIT outside flags word"); end
   if (TF_BIT >= DATA_W)         begin : g_bad_tf $error("TF_BIT outside flags word"); end
   if (IF_BIT == TF_BIT)         begin : g_bad_eq $error("flag bits must differ"); end

   logic [NUM_CH-1:0] req_v;
   logic [NUM_CH-1:0] take_v;
   logic [NUM_CH-1:0] pend_v;
   logic [VEC_W-1:0]  vin_v [NUM_CH];
   logic [VEC_W-1:0]  vq_v  [NUM_CH];

   seq_state_e        state;
   logic [DATA_W-1:0] ss_q, sp_q, flags_q, cs_q, ip_q;
   logic [VEC_W-1:0]  vec_q;
   logic              is_ret;

   assign req_v[CH_RET] = ret_req;
   assign req_v[CH_SW]  = sw_req;
   assign req_v[CH_HW]  = hw_req;
   assign vin_v[CH_RET] = '0;
   assign vin_v[CH_SW]  = sw_vec;
   assign vin_v[CH_HW]  = hw_vec;

   trap_req_latch #(
      .VEC_W (VEC_W),
      .NCH   (NUM_CH)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_v),
      .vin   (vin_v),
      .take  (take_v),
      .pend  (pend_v),
      .vq    (vq_v)
   );

   trap_seq_fsm #(
      .DATA_W (DATA_W),
      .VEC_W  (VEC_W),
      .IF_BIT (IF_BIT),
      .TF_BIT (TF_BIT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire    (retire),
      .pend      (pend_v),
      .vq        (vq_v),
      .take      (take_v),
      .flags_in  (flags_in),
      .cs_in     (cs_in),
      .ip_in     (ip_in),
      .ss_in     (ss_in),
      .sp_in     (sp_in),
      .mem_rdy   (mem_rdy),
      .mem_rdata (mem_rdata),
      .state     (state),
      .ss_q      (ss_q),
      .sp_q      (sp_q),
      .vec_q     (vec_q),
      .flags_q   (flags_q),
      .cs_q      (cs_q),
      .ip_q      (ip_q),
      .is_ret    (is_ret),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata)
   );

   trap_addr_gen #(
      .DATA_W    (DATA_W),
      .VEC_W     (VEC_W),
      .ADDR_W    (ADDR_W),
      .SEG_SHIFT (SEG_SHIFT)
   ) u_addr (
      .state    (state),
      .ss_q     (ss_q),
      .sp_q     (sp_q),
      .vec_q    (vec_q),
      .mem_addr (mem_addr)
   );

   assign busy      = (state != ST_IDLE);
   assign commit    = (state == ST_COMMIT);
   assign flags_out = flags_q;
   assign cs_out    = cs_q;
   assign ip_out    = ip_q;
   assign sp_out    = sp_q;

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
   parameter int DATA_W = 16,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 20,
   parameter int IF_BIT = 9,
   parameter int TF_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retire,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_rdy,
   input logic              commit,
   input logic [DATA_W-1:0] flags_out,
   input logic              ret_op
);

   // R1: a sequence only starts in a retire cycle
   p_start_on_retire_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(retire));

   // R3: table reads stay inside the vector table, word aligned
   p_table_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && !ret_op) |-> ((mem_addr >> (VEC_W + 2)) == 0) && !mem_addr[0]);

   // R4: entry commit has interrupt enable and single step cleared
   p_entry_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !ret_op) |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));

   // R5: a return never writes memory
   p_return_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && ret_op) |-> !mem_we);

   // R8: no memory traffic while idle
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R8: commit is a single cycle and ends the sequence
   p_commit_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (!commit && !busy));

   // R9: a stalled access holds its request, address, direction and data
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(
   .DATA_W (DATA_W),
   .VEC_W  (VEC_W),
   .ADDR_W (ADDR_W),
   .IF_BIT (IF_BIT),
   .TF_BIT (TF_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .retire    (retire),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdy   (mem_rdy),
   .commit    (commit),
   .flags_out (flags_out),
   .ret_op    (is_ret)
);

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/100ps
module test_trap_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire = 1'b0;
   logic        hw_req = 1'b0, sw_req = 1'b0, ret_req = 1'b0;
   logic [7:0]  hw_vec = '0, sw_vec = '0;
   logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
   logic        busy, mem_req, mem_we, mem_rdy = 1'b0, commit;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata = '0;
   logic [15:0] flags_out, cs_out, ip_out, sp_out;

   always #2.5 clk = ~clk;

   trap_entry_seq i_trap_entry_seq (
      .clk(clk), .rst_n(rst_n), .retire(retire),
      .hw_req(hw_req), .hw_vec(hw_vec), .sw_req(sw_req), .sw_vec(sw_vec), .ret_req(ret_req),
      .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .commit(commit), .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out)
   );

   int n_chk = 0, n_bad = 0, n_commit = 0, cyc = 0;
   logic        finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
      return (20'(seg) << 4) + 20'(off);
   endfunction

   function automatic logic [15:0] tbl_word(input logic [19:0] a);
      logic [7:0] v;
      v = a[9:2];
      return a[1] ? (16'h0800 + 16'(v)) : (16'h4000 + 16'(v) * 16'd37);
   endfunction

   // memory model with cycling latency
   logic [15:0] stk [logic [19:0]];
   logic [19:0] log_a [16];
   logic        log_w [16];
   logic [15:0] log_d [16];
   int          log_n = 0;
   int          wcnt = 0, lat_k = 0;
   logic        stalled = 1'b0;
   logic [19:0] prev_a;
   logic        prev_w;
   logic [15:0] prev_d;
   logic [15:0] cap_f, cap_cs, cap_ip, cap_sp;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         mem_rdy = 1'b0; wcnt = 0; stalled = 1'b0;
      end else if (mem_rdy) begin
         mem_rdy = 1'b0; stalled = 1'b0;
      end else if (mem_req) begin
         if (stalled) begin
            chk("R9 stalled address held", 32'(mem_addr), 32'(prev_a));
            chk("R9 stalled write data held", {15'd0, mem_we, mem_wdata}, {15'd0, prev_w, prev_d});
         end
         prev_a = mem_addr; prev_w = mem_we; prev_d = mem_wdata;
         if (wcnt == 0) begin
            mem_rdy = 1'b1;
            stalled = 1'b0;
            if (log_n < 16) begin
               log_a[log_n] = mem_addr; log_w[log_n] = mem_we; log_d[log_n] = mem_wdata;
            end
            log_n++;
            if (mem_we) stk[mem_addr] = mem_wdata;
            else if (mem_addr < 20'h400) mem_rdata = tbl_word(mem_addr);
            else if (stk.exists(mem_addr)) mem_rdata = stk[mem_addr];
            else mem_rdata = 16'hDEAD;
            lat_k = (lat_k + 1) % 4;
            wcnt = lat_k;
         end else begin
            wcnt--;
            stalled = 1'b1;
         end
      end
      if (commit) begin
         cap_f = flags_out; cap_cs = cs_out; cap_ip = ip_out; cap_sp = sp_out;
         n_commit++;
      end
   end

   // watchdog
   always @(negedge clk) begin
      if (cyc > 150000 && !finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse(input int which, input logic [7:0] v);
      if (which == 0) ret_req = 1'b1;
      else if (which == 1) begin sw_req = 1'b1; sw_vec = v; end
      else begin hw_req = 1'b1; hw_vec = v; end
      step();
      ret_req = 1'b0; sw_req = 1'b0; hw_req = 1'b0;
   endtask

   task automatic do_retire();
      retire = 1'b1;
      step();
      retire = 1'b0;
   endtask

   task automatic wait_commit(input int c0, input string tag);
      int t = 0;
      while (n_commit == c0 && t < 300) begin step(); t++; end
      chk({tag, " sequence completes"}, 32'(n_commit), 32'(c0 + 1));
   endtask

   task automatic set_cpu(input logic [15:0] f, input logic [15:0] c, input logic [15:0] i,
                          input logic [15:0] s, input logic [15:0] p);
      flags_in = f; cs_in = c; ip_in = i; ss_in = s; sp_in = p;
   endtask

   // check the five accesses and the commit of an entry that began with log_n == 0
   task automatic check_entry(input string tag, input logic [7:0] v, input logic [15:0] f,
                              input logic [15:0] c, input logic [15:0] i,
                              input logic [15:0] s, input logic [15:0] p);
      chk({tag, " R2 access count"}, 32'(log_n), 32'd5);
      chk({tag, " R2 flags push"}, {log_w[0], 11'd0, log_a[0]}, {1'b1, 11'd0, phys(s, p - 16'd2)});
      chk({tag, " R2 flags data"}, 32'(log_d[0]), 32'(f));
      chk({tag, " R2 cs push"}, {log_w[1], 11'd0, log_a[1]}, {1'b1, 11'd0, phys(s, p - 16'd4)});
      chk({tag, " R2 cs data"}, 32'(log_d[1]), 32'(c));
      chk({tag, " R2 ip push"}, {log_w[2], 11'd0, log_a[2]}, {1'b1, 11'd0, phys(s, p - 16'd6)});
      chk({tag, " R2 ip data"}, 32'(log_d[2]), 32'(i));
      chk({tag, " R3 offset read"}, {log_w[3], 11'd0, log_a[3]}, {1'b0, 11'd0, 20'(v) * 20'd4});
      chk({tag, " R3 segment read"}, {log_w[4], 11'd0, log_a[4]}, {1'b0, 11'd0, 20'(v) * 20'd4 + 20'd2});
      chk({tag, " R4 new ip"}, 32'(cap_ip), 32'(16'h4000 + 16'(v) * 16'd37));
      chk({tag, " R4 new cs"}, 32'(cap_cs), 32'(16'h0800 + 16'(v)));
      chk({tag, " R4 new flags"}, 32'(cap_f), 32'(f & 16'hFCFF));
      chk({tag, " R4 new sp"}, 32'(cap_sp), 32'(p - 16'd6));
   endtask

   initial begin
      int c0;
      logic [15:0] f;
      // reset
      step(); step();
      chk("reset busy R8", 32'(busy), 32'd0);
      chk("reset mem_req R9", 32'(mem_req), 32'd0);
      chk("reset commit R8", 32'(commit), 32'd0);
      rst_n = 1'b1;
      step();

      // R6 sweep: every vector as a software trap, IF bit varies per vector
      for (int v = 0; v < 256; v++) begin
         f = {8'(v), ~8'(v)};
         set_cpu(f, 16'h1200 + 16'(v), 16'h0100 + 16'(v) * 16'd3, 16'h3000, 16'hFFF0 - 16'(v) * 16'd2);
         log_n = 0;
         c0 = n_commit;
         pulse(1, 8'(v));
         step(); step();
         chk("R1 no start before retire", 32'(busy), 32'd0);
         do_retire();
         wait_commit(c0, "R6 sw trap");
         step();
         check_entry("R6", 8'(v), f, cs_in, ip_in, ss_in, sp_in);
      end

      // R7: masked hardware request waits, then is taken with IF set
      set_cpu(16'h0000, 16'hA000, 16'h0222, 16'h3100, 16'h0800);
      log_n = 0;
      c0 = n_commit;
      pulse(2, 8'h21);
      do_retire();
      repeat (8) step();
      chk("R7 masked hw not taken (busy)", 32'(busy), 32'd0);
      chk("R7 masked hw not taken (commits)", 32'(n_commit), 32'(c0));
      chk("R7 masked hw no memory traffic", 32'(log_n), 32'd0);
      flags_in = 16'h0200;
      repeat (3) step();
      chk("R1 hw pending needs retire", 32'(busy), 32'd0);
      do_retire();
      wait_commit(c0, "R7 hw after unmask");
      step();
      check_entry("R7", 8'h21, 16'h0200, 16'hA000, 16'h0222, 16'h3100, 16'h0800);

      // R5: return pops IP, CS, flags
      set_cpu(16'h0200, 16'h5555, 16'h6666, 16'h3200, 16'h07F0);
      stk[phys(16'h3200, 16'h07F0)] = 16'h1357;
      stk[phys(16'h3200, 16'h07F2)] = 16'h2468;
      stk[phys(16'h3200, 16'h07F4)] = 16'h0BD5;
      log_n = 0;
      c0 = n_commit;
      pulse(0, 8'h00);
      do_retire();
      wait_commit(c0, "R5 return");
      step();
      chk("R5 access count", 32'(log_n), 32'd3);
      chk("R5 pop ip addr", {log_w[0], 11'd0, log_a[0]}, {1'b0, 11'd0, phys(16'h3200, 16'h07F0)});
      chk("R5 pop cs addr", {log_w[1], 11'd0, log_a[1]}, {1'b0, 11'd0, phys(16'h3200, 16'h07F2)});
      chk("R5 pop flags addr", {log_w[2], 11'd0, log_a[2]}, {1'b0, 11'd0, phys(16'h3200, 16'h07F4)});
      chk("R5 restored ip", 32'(cap_ip), 32'h1357);
      chk("R5 restored cs", 32'(cap_cs), 32'h2468);
      chk("R5 restored flags", 32'(cap_f), 32'h0BD5);
      chk("R5 restored sp", 32'(cap_sp), 32'h07F6);

      // R5 round trip: entry followed by return restores the original state
      set_cpu(16'h0B17, 16'h7700, 16'h0404, 16'h3300, 16'h1000);
      log_n = 0; c0 = n_commit;
      pulse(2, 8'h09);
      do_retire();
      wait_commit(c0, "R2 hw entry");
      step();
      check_entry("R2", 8'h09, 16'h0B17, 16'h7700, 16'h0404, 16'h3300, 16'h1000);
      set_cpu(cap_f, cap_cs, cap_ip, 16'h3300, cap_sp);
      log_n = 0; c0 = n_commit;
      pulse(0, 8'h00);
      do_retire();
      wait_commit(c0, "R5 round trip");
      step();
      chk("R5 round trip flags", 32'(cap_f), 32'h0B17);
      chk("R5 round trip cs", 32'(cap_cs), 32'h7700);
      chk("R5 round trip ip", 32'(cap_ip), 32'h0404);
      chk("R5 round trip sp", 32'(cap_sp), 32'h1000);

      // R10: software beats hardware, return beats software
      set_cpu(16'h0200, 16'h1111, 16'h2222, 16'h3400, 16'h0900);
      pulse(2, 8'h40);
      pulse(1, 8'h41);
      log_n = 0; c0 = n_commit;
      do_retire();
      wait_commit(c0, "R10 first");
      step();
      chk("R10 sw before hw", 32'(log_a[3]), 32'(20'h41 * 4));
      log_n = 0; c0 = n_commit;
      do_retire();
      wait_commit(c0, "R10 second");
      step();
      chk("R10 hw served next", 32'(log_a[3]), 32'(20'h40 * 4));
      stk[phys(16'h3400, 16'h0900)] = 16'h00AA;
      stk[phys(16'h3400, 16'h0902)] = 16'h00BB;
      stk[phys(16'h3400, 16'h0904)] = 16'h00CC;
      pulse(1, 8'h42);
      pulse(0, 8'h00);
      log_n = 0; c0 = n_commit;
      do_retire();
      wait_commit(c0, "R10 third");
      step();
      chk("R10 return before sw", {log_w[0], 11'd0, log_a[0]}, {1'b0, 11'd0, phys(16'h3400, 16'h0900)});
      chk("R10 return value", 32'(cap_ip), 32'h00AA);
      log_n = 0; c0 = n_commit;
      do_retire();
      wait_commit(c0, "R10 fourth");
      step();
      chk("R10 sw served after return", 32'(log_a[3]), 32'(20'h42 * 4));

      // R8: busy through the sequence, request during busy is held
      set_cpu(16'h0200, 16'h1000, 16'h2000, 16'h3500, 16'h0A00);
      pulse(1, 8'h10);
      log_n = 0; c0 = n_commit;
      retire = 1'b1;
      step();
      retire = 1'b0;
      chk("R8 busy after accept", 32'(busy), 32'd1);
      pulse(2, 8'h11);
      retire = 1'b1;
      step();
      retire = 1'b0;
      chk("R8 busy mid sequence", 32'(busy), 32'd1);
      wait_commit(c0, "R8 entry");
      step();
      chk("R8 busy low after commit", 32'(busy), 32'd0);
      chk("R8 single commit", 32'(n_commit), 32'(c0 + 1));
      chk("R8 first vector kept", 32'(log_a[3]), 32'(20'h10 * 4));
      repeat (4) step();
      chk("R8 held request waits for retire", 32'(busy), 32'd0);
      log_n = 0; c0 = n_commit;
      do_retire();
      wait_commit(c0, "R8 held request");
      step();
      chk("R8 held request served", 32'(log_a[3]), 32'(20'h11 * 4));

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule